// File: doc/BRIEF.md
# Transfer Queue Overlay Engine

This block runs the transfer descriptors queued behind one endpoint's queue head. Every non-isochronous transfer for an endpoint goes through one such queue. The queue is a linked list of descriptors in memory. Each time the scheduler visits the queue head, the engine reads the queue head's link word. If that link names a descriptor whose active flag is set, the engine copies the descriptor into the overlay area of the queue head. The queue head therefore takes over the descriptor's own link as its next pointer. The engine then hands the overlay to a transaction executor. When the executor reports completion, the engine writes the final status and remaining byte count back, with the active flag cleared.

Software may append descriptors at the tail at any time without any handshake. The engine holds no cached link between visits: every visit re-reads the queue head. A terminated link or an inactive descriptor ends the visit with no memory write, and the next visit tries again. Memory is reached through a single request/acknowledge port with one outstanding access and any latency. All addresses on that port are word addresses. A link word carries a terminate flag in bit 0 and the target word address in bits [ADDR_W+1:2].

Top module: `qoe_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `mem_req_o`, `exec_req_o` and `visit_done_o` are low. While idle it issues no memory request and no execute request.
- R2: A visit reads the queue head link at word `qh_base_i`+0. If bit 0 (terminate) of that word is set, the visit ends with `visit_result_o` = 0. It makes exactly one read, no write and no execute request.
- R3: Otherwise the engine reads the token word at descriptor word +1. If bit 7 (active) of the token is clear, the visit ends with result 1. It makes exactly two reads, no write and no execute request, and the queue head is left unchanged.
- R4: For an active descriptor, the engine reads descriptor words +0 (link) and +2 (buffer). It then writes the queue head: +1 gets the descriptor's link word (current pointer), +0 gets the descriptor's own link, +2 gets the token and +3 gets the buffer.
- R5: After the copy, `exec_req_o` stays high until `exec_done_i`. During that time `exec_token_o` and `exec_buf_o` show the copied token and buffer, and the token's active bit is set.
- R6: On `exec_done_i` the engine builds a write-back token. Bit 31 and bits [15:8] are kept from the old token. Bits [30:16] take `exec_left_i`, bit 7 is cleared and bits [6:0] take `exec_status_i`. The engine writes this token to word +1 of the descriptor named by the current pointer, then to queue head word +2. The visit then ends with result 2, after four reads and six writes in total.
- R7: Successive visits walk the chain through the inherited next pointer. A descriptor that is linked in, or made active, after an unsuccessful visit is picked up by the next visit.
- R8: A memory request keeps `mem_req_o`, `mem_we_o` and `mem_addr_o` unchanged until `mem_ack_i`. The engine works for any acknowledge latency.
- R9: A visit pulse while `busy_o` is high is ignored. It starts no second visit and touches no memory at the other base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| visit_i | input | 1 | Schedule visit pulse, taken while idle |
| qh_base_i | input | ADDR_W | Queue head word address, sampled with the visit |
| busy_o | output | 1 | A visit is in progress |
| visit_done_o | output | 1 | One-cycle pulse at the end of a visit |
| visit_result_o | output | 2 | 0 terminated, 1 inactive, 2 executed; valid with the done pulse |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| exec_req_o | output | 1 | Overlay ready for the transaction executor |
| exec_token_o | output | 32 | Overlay token |
| exec_buf_o | output | 32 | Overlay buffer pointer |
| exec_done_i | input | 1 | Executor finished |
| exec_status_i | input | 7 | Final status from the executor |
| exec_left_i | input | 15 | Bytes left from the executor |

## Verification
The bench walks a three-descriptor chain under acknowledge latencies from zero to three cycles. After each visit it checks the queue head image. An engine that did not inherit the descriptor's link would execute the same descriptor again instead of moving on. An engine that wrote back through the queue head address rather than the stored current pointer would leave the descriptor marked active. After the chain ends, the bench checks that a terminated link and an inactive tail cause no writes. A design that trusted a stale link, or wrote the overlay before testing the active flag, would corrupt the queue head there. The bench then sets the tail active and links it in between visits, and checks that the very next visit picks it up. A visit pulse sent during execution checks that a busy engine never starts over at a second base address.

// File: rtl/qoe_pkg.sv
// Package: shared layout constants and types of the queue overlay engine.
// Assumes 32-bit memory words and word addressing for queue heads and descriptors.
package qoe_pkg;

    localparam int WORD_W   = 32;
    localparam int TERM_BIT = 0;    // link word: terminate flag
    localparam int ACT_BIT  = 7;    // token: active flag
    localparam int PTR_LSB  = 2;    // link word: first address bit

    // queue head word offsets
    localparam int QH_NEXT = 0;
    localparam int QH_CUR  = 1;
    localparam int QH_TOK  = 2;
    localparam int QH_BUF  = 3;

    // descriptor word offsets
    localparam int TD_NEXT = 0;
    localparam int TD_TOK  = 1;
    localparam int TD_BUF  = 2;

    localparam int STEP_W    = 3;
    localparam int COPY_LAST = 5;   // two reads then four queue head writes
    localparam int WB_LAST   = 1;   // descriptor token then queue head token

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_CHECK = 3'd2,
        S_COPY  = 3'd3,
        S_EXEC  = 3'd4,
        S_WB    = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_TERM  = 2'd0,
        RES_INACT = 2'd1,
        RES_RAN   = 2'd2
    } visit_res_t;

endpackage

// File: rtl/qoe_overlay.sv
// Module: queue head overlay image.
// Holds the current pointer, inherited next link, token and buffer of the
// descriptor being run. Loads happen only on strobes from the sequencer, which
// assumes an active descriptor was seen before the first strobe.
module qoe_overlay
    import qoe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_copy_i,
    input  logic              ld_buf_i,
    input  logic              ld_wb_i,
    input  logic [WORD_W-1:0] cur_in_i,
    input  logic [WORD_W-1:0] tok_in_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  logic [WORD_W-1:0] wb_tok_i,
    output logic [WORD_W-1:0] cur_o,
    output logic [WORD_W-1:0] nxt_o,
    output logic [WORD_W-1:0] tok_o,
    output logic [WORD_W-1:0] buf_o
);

    logic [WORD_W-1:0] cur_q, nxt_q, tok_q, buf_q;

    // Capture overlay fields as the copy and write-back steps complete.
    always_ff @(posedge clk) begin : ovl_regs_p
        if (!rst_n) begin
            cur_q <= '0;
            nxt_q <= '0;
            tok_q <= '0;
            buf_q <= '0;
        end else begin
            if (ld_copy_i) begin
                cur_q <= cur_in_i;
                tok_q <= tok_in_i;
                nxt_q <= rdata_i;
            end
            if (ld_buf_i) begin
                buf_q <= rdata_i;
            end
            if (ld_wb_i) begin
                tok_q <= wb_tok_i;
            end
        end
    end

    assign cur_o = cur_q;
    assign nxt_o = nxt_q;
    assign tok_o = tok_q;
    assign buf_o = buf_q;

    AST_CUR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_copy_i |-> (!cur_in_i[TERM_BIT] && tok_in_i[ACT_BIT])); // R4

endmodule

// File: rtl/qoe_memcmd.sv
// Module: memory command builder.
// Turns sequencer state and step into the request, direction, word address and
// write data of the single outstanding memory access. Purely combinational;
// assumes the sequencer only advances on acknowledge.
module qoe_memcmd
    import qoe_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [ADDR_W-1:0] qh_addr_i,
    input  logic [WORD_W-1:0] link_i,
    input  logic [WORD_W-1:0] ovl_cur_i,
    input  logic [WORD_W-1:0] ovl_nxt_i,
    input  logic [WORD_W-1:0] ovl_tok_i,
    input  logic [WORD_W-1:0] ovl_buf_i,
    input  logic [WORD_W-1:0] wb_tok_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o
);

    logic [ADDR_W-1:0] link_addr;
    logic [ADDR_W-1:0] cur_addr;

    assign link_addr = link_i[ADDR_W+PTR_LSB-1:PTR_LSB];
    assign cur_addr  = ovl_cur_i[ADDR_W+PTR_LSB-1:PTR_LSB];

    // Select the access for the present state and step.
    always_comb begin : cmd_sel_p
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        unique case (state_i)
            S_FETCH: begin
                req_o  = 1'b1;
                addr_o = qh_addr_i + ADDR_W'(QH_NEXT);
            end
            S_CHECK: begin
                req_o  = 1'b1;
                addr_o = link_addr + ADDR_W'(TD_TOK);
            end
            S_COPY: begin
                req_o = 1'b1;
                unique case (step_i)
                    3'd0: addr_o = link_addr + ADDR_W'(TD_NEXT);
                    3'd1: addr_o = link_addr + ADDR_W'(TD_BUF);
                    3'd2: begin
                        we_o    = 1'b1;
                        addr_o  = qh_addr_i + ADDR_W'(QH_CUR);
                        wdata_o = ovl_cur_i;
                    end
                    3'd3: begin
                        we_o    = 1'b1;
                        addr_o  = qh_addr_i + ADDR_W'(QH_NEXT);
                        wdata_o = ovl_nxt_i;
                    end
                    3'd4: begin
                        we_o    = 1'b1;
                        addr_o  = qh_addr_i + ADDR_W'(QH_TOK);
                        wdata_o = ovl_tok_i;
                    end
                    default: begin
                        we_o    = 1'b1;
                        addr_o  = qh_addr_i + ADDR_W'(QH_BUF);
                        wdata_o = ovl_buf_i;
                    end
                endcase
            end
            S_WB: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                wdata_o = wb_tok_i;
                if (step_i == STEP_W'(0)) begin
                    addr_o = cur_addr + ADDR_W'(TD_TOK);
                end else begin
                    addr_o = qh_addr_i + ADDR_W'(QH_TOK);
                end
            end
            default: begin
                req_o = 1'b0;
            end
        endcase
    end

    AST_WB_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && we_o && state_i == S_WB) |-> !wdata_o[ACT_BIT]); // R6

endmodule

// File: rtl/qoe_seq.sv
// Module: visit sequencer.
// Runs idle, fetch next, check active, copy overlay, execute and write back
// for one queue head per visit. Assumes one memory access outstanding and
// that the acknowledge cycle also carries read data.
module qoe_seq
    import qoe_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              visit_i,
    input  logic [ADDR_W-1:0] qh_base_i,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              exec_done_i,
    input  logic [6:0]        exec_status_i,
    input  logic [14:0]       exec_left_i,
    output seq_state_t        state_o,
    output logic [STEP_W-1:0] step_o,
    output logic [ADDR_W-1:0] qh_addr_o,
    output logic [WORD_W-1:0] link_o,
    output logic [WORD_W-1:0] chk_tok_o,
    output logic [WORD_W-1:0] wb_tok_o,
    output logic              ld_copy_o,
    output logic              ld_buf_o,
    output logic              ld_wb_o,
    output logic              exec_req_o,
    output logic              done_o,
    output visit_res_t        result_o
);

    seq_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] qh_q;
    logic [WORD_W-1:0] link_q;
    logic [WORD_W-1:0] chk_tok_q;
    logic [WORD_W-1:0] wb_tok_q;
    logic              done_q;
    visit_res_t        res_q;

    // Advance the visit on each acknowledge or executor completion.
    always_ff @(posedge clk) begin : seq_fsm_p
        if (!rst_n) begin
            state_q   <= S_IDLE;
            step_q    <= '0;
            qh_q      <= '0;
            link_q    <= '0;
            chk_tok_q <= '0;
            wb_tok_q  <= '0;
            done_q    <= 1'b0;
            res_q     <= RES_TERM;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (visit_i) begin
                        qh_q    <= qh_base_i;
                        state_q <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_ack_i) begin
                        link_q <= mem_rdata_i;
                        if (mem_rdata_i[TERM_BIT]) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                            res_q   <= RES_TERM;
                        end else begin
                            state_q <= S_CHECK;
                        end
                    end
                end
                S_CHECK: begin
                    if (mem_ack_i) begin
                        chk_tok_q <= mem_rdata_i;
                        if (!mem_rdata_i[ACT_BIT]) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                            res_q   <= RES_INACT;
                        end else begin
                            state_q <= S_COPY;
                            step_q  <= '0;
                        end
                    end
                end
                S_COPY: begin
                    if (mem_ack_i) begin
                        if (step_q == STEP_W'(COPY_LAST)) begin
                            state_q <= S_EXEC;
                            step_q  <= '0;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                S_EXEC: begin
                    if (exec_done_i) begin
                        wb_tok_q <= {chk_tok_q[31], exec_left_i, chk_tok_q[15:8],
                                     1'b0, exec_status_i};
                        state_q  <= S_WB;
                        step_q   <= '0;
                    end
                end
                S_WB: begin
                    if (mem_ack_i) begin
                        if (step_q == STEP_W'(WB_LAST)) begin
                            state_q <= S_IDLE;
                            step_q  <= '0;
                            done_q  <= 1'b1;
                            res_q   <= RES_RAN;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    // Load strobes for the overlay image.
    always_comb begin : ld_strobe_p
        ld_copy_o = (state_q == S_COPY) && (step_q == STEP_W'(0)) && mem_ack_i;
        ld_buf_o  = (state_q == S_COPY) && (step_q == STEP_W'(1)) && mem_ack_i;
        ld_wb_o   = (state_q == S_WB) && (step_q == STEP_W'(WB_LAST)) && mem_ack_i;
    end

    assign state_o    = state_q;
    assign step_o     = step_q;
    assign qh_addr_o  = qh_q;
    assign link_o     = link_q;
    assign chk_tok_o  = chk_tok_q;
    assign wb_tok_o   = wb_tok_q;
    assign exec_req_o = (state_q == S_EXEC);
    assign done_o     = done_q;
    assign result_o   = res_q;

    AST_VISIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && visit_i) |=> $stable(qh_q)); // R9

    AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && mem_ack_i && mem_rdata_i[TERM_BIT])
        |=> (state_q == S_IDLE && done_q && res_q == RES_TERM)); // R2

    AST_INACT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && mem_ack_i && !mem_rdata_i[ACT_BIT])
        |=> (state_q == S_IDLE && done_q && res_q == RES_INACT)); // R3

endmodule

// File: rtl/qoe_engine.sv
// Module: transfer queue overlay engine (top).
// Serves one queue head per visit: follows its link, tests the descriptor's
// active flag, copies it into the queue head overlay, hands it to an executor
// and writes the result back. Assumes the memory port accepts one request at a
// time and returns read data with the acknowledge.
module qoe_engine
    import qoe_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              visit_i,
    input  logic [ADDR_W-1:0] qh_base_i,
    output logic              busy_o,
    output logic              visit_done_o,
    output logic [1:0]        visit_result_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              exec_req_o,
    output logic [31:0]       exec_token_o,
    output logic [31:0]       exec_buf_o,
    input  logic              exec_done_i,
    input  logic [6:0]        exec_status_i,
    input  logic [14:0]       exec_left_i
);

    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] qh_addr;
    logic [WORD_W-1:0] link, chk_tok, wb_tok;
    logic              ld_copy, ld_buf, ld_wb;
    logic [WORD_W-1:0] ovl_cur, ovl_nxt, ovl_tok, ovl_buf;
    visit_res_t        result;

    qoe_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .visit_i       (visit_i),
        .qh_base_i     (qh_base_i),
        .mem_ack_i     (mem_ack_i),
        .mem_rdata_i   (mem_rdata_i),
        .exec_done_i   (exec_done_i),
        .exec_status_i (exec_status_i),
        .exec_left_i   (exec_left_i),
        .state_o       (state),
        .step_o        (step),
        .qh_addr_o     (qh_addr),
        .link_o        (link),
        .chk_tok_o     (chk_tok),
        .wb_tok_o      (wb_tok),
        .ld_copy_o     (ld_copy),
        .ld_buf_o      (ld_buf),
        .ld_wb_o       (ld_wb),
        .exec_req_o    (exec_req_o),
        .done_o        (visit_done_o),
        .result_o      (result)
    );

    qoe_overlay ovl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_copy_i (ld_copy),
        .ld_buf_i  (ld_buf),
        .ld_wb_i   (ld_wb),
        .cur_in_i  (link),
        .tok_in_i  (chk_tok),
        .rdata_i   (mem_rdata_i),
        .wb_tok_i  (wb_tok),
        .cur_o     (ovl_cur),
        .nxt_o     (ovl_nxt),
        .tok_o     (ovl_tok),
        .buf_o     (ovl_buf)
    );

    qoe_memcmd #(.ADDR_W(ADDR_W)) cmd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .step_i    (step),
        .qh_addr_i (qh_addr),
        .link_i    (link),
        .ovl_cur_i (ovl_cur),
        .ovl_nxt_i (ovl_nxt),
        .ovl_tok_i (ovl_tok),
        .ovl_buf_i (ovl_buf),
        .wb_tok_i  (wb_tok),
        .req_o     (mem_req_o),
        .we_o      (mem_we_o),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_wdata_o)
    );

    assign busy_o         = (state != S_IDLE);
    assign visit_result_o = result;
    assign exec_token_o   = ovl_tok;
    assign exec_buf_o     = ovl_buf;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !exec_req_o)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> mem_req_o); // R8

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> ($stable(mem_addr_o) && $stable(mem_we_o))); // R8

    AST_EXEC_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req_o |-> exec_token_o[ACT_BIT]); // R5

    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req_o && !exec_done_i) |=> (exec_req_o && $stable(exec_token_o))); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        visit_done_o |-> !busy_o); // R9

endmodule

// File: tb/qoe_engine_tb_top.sv
// Bench: memory and executor models, chain walks under several ack latencies.
module qoe_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        visit_i = 1'b0;
    logic [15:0] qh_base_i = '0;
    logic        busy_o, visit_done_o;
    logic [1:0]  visit_result_o;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        exec_req_o;
    logic [31:0] exec_token_o, exec_buf_o;
    logic        exec_done_i = 1'b0;
    logic [6:0]  exec_status_i = '0;
    logic [14:0] exec_left_i = '0;

    always #2 clk = ~clk;

    qoe_engine dut_i (
        .clk(clk), .rst_n(rst_n), .visit_i(visit_i), .qh_base_i(qh_base_i),
        .busy_o(busy_o), .visit_done_o(visit_done_o), .visit_result_o(visit_result_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .exec_req_o(exec_req_o), .exec_token_o(exec_token_o), .exec_buf_o(exec_buf_o),
        .exec_done_i(exec_done_i), .exec_status_i(exec_status_i), .exec_left_i(exec_left_i)
    );

    logic [31:0] mem [0:63];
    int lat = 0, mcnt = 0, rd_cnt = 0, wr_cnt = 0, ex_cnt = 0, done_cnt = 0, ecnt = 0;
    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [31:0] seen_tok, seen_buf, qh_tok_at_exec;

    // Memory model: one access, acknowledged after lat idle cycles.
    initial forever begin
        @(negedge clk);
        if (mem_ack_i) begin
            mem_ack_i = 1'b0;
        end else if (mem_req_o) begin
            if (mcnt >= lat) begin
                mcnt = 0;
                if (mem_we_o) begin
                    mem[mem_addr_o[5:0]] = mem_wdata_o;
                    wr_cnt++;
                end else begin
                    mem_rdata_i = mem[mem_addr_o[5:0]];
                    rd_cnt++;
                end
                mem_ack_i = 1'b1;
            end else begin
                mcnt++;
            end
        end
    end

    // Executor model: halves the byte count, status from the low count bits.
    initial forever begin
        @(negedge clk);
        if (exec_done_i) begin
            exec_done_i = 1'b0;
        end else if (exec_req_o) begin
            if (ecnt == 2) begin
                ecnt = 0;
                seen_tok = exec_token_o;
                seen_buf = exec_buf_o;
                qh_tok_at_exec = mem[2];
                exec_left_i = exec_token_o[30:16] >> 1;
                exec_status_i = exec_token_o[22:16] ^ 7'h15;
                exec_done_i = 1'b1;
                ex_cnt++;
            end else begin
                ecnt++;
            end
        end
    end

    initial forever begin
        @(negedge clk);
        if (visit_done_o) done_cnt++;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ptr(input int a);
        return 32'(a) << 2;
    endfunction

    function automatic logic [31:0] mk_tok(input int bytes, input int misc, input bit act);
        return {1'b0, 15'(bytes), 8'(misc), act, 7'h00};
    endfunction

    function automatic logic [31:0] exp_wb(input int bytes, input int misc);
        logic [14:0] b;
        b = 15'(bytes);
        return {1'b0, b >> 1, 8'(misc), 1'b0, b[6:0] ^ 7'h15};
    endfunction

    task automatic run_visit(input logic [15:0] qh);
        int t;
        rd_cnt = 0; wr_cnt = 0; ex_cnt = 0;
        @(negedge clk);
        qh_base_i = qh;
        visit_i = 1'b1;
        @(negedge clk);
        visit_i = 1'b0;
        t = 0;
        while (!visit_done_o && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (!visit_done_o) begin
            total++; bad++;
            $display("FAIL visit watchdog act=%0d exp=done", t);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 32'(busy_o), 0);
        chk("R1", "req", 32'(mem_req_o), 0);
        chk("R1", "exec", 32'(exec_req_o), 0);
        chk("R1", "done", 32'(visit_done_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle req", 32'(mem_req_o), 0);

        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int i = 0; i < 64; i++) mem[i] = '0;
            mem[0] = ptr(8);
            for (int d = 0; d < 3; d++) begin
                mem[8 + 4*d]     = (d == 2) ? 32'h1 : ptr(12 + 4*d);
                mem[8 + 4*d + 1] = mk_tok(100*l + 37*d + 5, 8'hA0 + d, 1'b1);
                mem[8 + 4*d + 2] = 32'h0010_0000 + 32'(256*d + l);
            end
            for (int d = 0; d < 3; d++) begin
                int a, by;
                a = 8 + 4*d;
                by = 100*l + 37*d + 5;
                run_visit(16'h0000);
                // R6 / R7: walk and write-back
                chk("R6", "result", 32'(visit_result_o), 2);
                chk("R6", "reads", 32'(rd_cnt), 4);
                chk("R6", "writes", 32'(wr_cnt), 6);
                chk("R5", "exec token", seen_tok, mk_tok(by, 8'hA0 + d, 1'b1));
                chk("R5", "exec buf", seen_buf, 32'h0010_0000 + 32'(256*d + l));
                chk("R4", "qh tok copy", qh_tok_at_exec, mk_tok(by, 8'hA0 + d, 1'b1));
                chk("R4", "qh cur", mem[1], ptr(a));
                chk("R7", "qh next inherit", mem[0], (d == 2) ? 32'h1 : ptr(a + 4));
                chk("R4", "qh buf", mem[3], 32'h0010_0000 + 32'(256*d + l));
                chk("R6", "desc tok", mem[a + 1], exp_wb(by, 8'hA0 + d));
                chk("R6", "qh tok", mem[2], exp_wb(by, 8'hA0 + d));
            end
            // R2: terminated link
            run_visit(16'h0000);
            chk("R2", "result", 32'(visit_result_o), 0);
            chk("R2", "reads", 32'(rd_cnt), 1);
            chk("R2", "writes", 32'(wr_cnt), 0);
            chk("R2", "exec", 32'(ex_cnt), 0);
            // R3: inactive tail appended by software
            mem[20] = 32'h1;
            mem[21] = mk_tok(50 + l, 8'h3C, 1'b0);
            mem[22] = 32'h0020_0000 + 32'(l);
            mem[0]  = ptr(20);
            run_visit(16'h0000);
            chk("R3", "result", 32'(visit_result_o), 1);
            chk("R3", "reads", 32'(rd_cnt), 2);
            chk("R3", "writes", 32'(wr_cnt), 0);
            chk("R3", "qh next kept", mem[0], ptr(20));
            chk("R3", "exec", 32'(ex_cnt), 0);
            // R7: retried after being made active
            mem[21] = mk_tok(50 + l, 8'h3C, 1'b1);
            run_visit(16'h0000);
            chk("R7", "retry result", 32'(visit_result_o), 2);
            chk("R7", "retry desc tok", mem[21], exp_wb(50 + l, 8'h3C));
            chk("R7", "retry qh next", mem[0], 32'h1);
            // R8: latency sweep consistency
            chk("R8", "retry cur", mem[1], ptr(20));
        end

        // R9: visit pulse while busy
        lat = 1;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[0] = ptr(8);
        mem[8] = 32'h1;
        mem[9] = mk_tok(64, 8'h11, 1'b1);
        mem[40] = ptr(12);
        mem[12] = 32'h1;
        mem[13] = mk_tok(9, 8'h22, 1'b1);
        begin
            int t, d0;
            d0 = done_cnt;
            @(negedge clk);
            qh_base_i = 16'h0000;
            visit_i = 1'b1;
            @(negedge clk);
            visit_i = 1'b0;
            t = 0;
            while (!exec_req_o && t < 2000) begin @(negedge clk); t++; end
            qh_base_i = 16'd40;
            visit_i = 1'b1;
            @(negedge clk);
            visit_i = 1'b0;
            repeat (60) @(negedge clk);
            chk("R9", "done pulses", 32'(done_cnt - d0), 1);
            chk("R9", "busy", 32'(busy_o), 0);
            chk("R9", "other qh cur", mem[41], 0);
            chk("R9", "other desc tok", mem[13], mk_tok(9, 8'h22, 1'b1));
            chk("R9", "first desc tok", mem[9], exp_wb(64, 8'h11));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule